// File: doc/BRIEF.md
# PLL Divider Search Engine

This block turns a reference frequency and a requested output frequency, both given in kHz, into a divider setting for a PLL. A request starts with a one-cycle strobe. The engine then steps through the input (reference) divider values. For each one it derives the feedback multiplier and the frequency that pair would produce. It keeps the pair that lands closest to the request. From the chosen multiplier it also works out a charge-pump code.

When the search ends, the block raises `done` for one cycle. It presents a `valid` flag, the divider pair, the charge-pump code and the achieved rate in Hz. All divisions go through one shared restoring divider that produces one quotient bit per cycle, so a search takes several hundred cycles. The results stay on the outputs until the next completed search. Writing the settings into a PLL is left to the logic around the block.

Top module: `pll_divsearch`

## Requirements
- R1: A request is accepted only when `req_khz` lies between 800000 and 1600000 inclusive and `ref_khz` is non-zero. Any other request completes with `valid` low.
- R2: The reference divider d takes the values 1, 2 and so on up to 7, in that order. For each d the multiplier is m = floor(d * req_khz / (2 * ref_khz)).
- R3: A value of d whose multiplier m is below 8 is skipped, and the search continues with the next d.
- R4: A multiplier m above 200 ends the search at once. No larger d is tried, and any pair already kept is still reported.
- R5: The frequency achieved by a pair is floor(2 * ref_khz * m / d). Its error is the absolute difference from `req_khz`.
- R6: A pair replaces the kept one only if its error is zero or strictly smaller than the kept error, so the smallest d wins a tie. Once a zero-error pair is kept, the search stops.
- R7: If no pair was ever kept, `valid` is low and `idf`, `ndiv`, `cp` and `rate_hz` are all zero.
- R8: `cp` equals 6 plus the number of thresholds 48, 56, 64, and so on up to 192 (19 values, step 8) that `ndiv` is strictly greater than. Its range is therefore 6 to 25.
- R9: When `valid` is high, `rate_hz` equals the achieved frequency of the kept pair times 1000.
- R10: `done` is a single-cycle pulse. The outputs change only in the cycle in which `done` is high and hold their values until then. A `start` that arrives during a search is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| ref_khz | input | 32 | Reference frequency in kHz |
| req_khz | input | 32 | Requested output frequency in kHz |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | A divider pair was found |
| idf | output | 3 | Chosen reference divider |
| ndiv | output | 8 | Chosen feedback multiplier |
| cp | output | 5 | Charge-pump code |
| rate_hz | output | 40 | Achieved output rate in Hz |

## Verification
The hardest behaviour to reach from the ports is the multiplier crossing 200 in the middle of a search, after a non-exact pair has already been kept. The engine must then stop and still report that earlier pair. The stimulus reaches this by choosing a low reference together with an awkward request, so that the multiplier grows past the limit within a few divider steps. Further requests target an exact match on a later divider (the early stop), multipliers of 193 to 200 (the top charge-pump code), both edges of the accepted request range, and a second strobe that arrives while a search is running.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam logic [31:0] OUT_MIN_KHZ = 32'd800000;
    localparam logic [31:0] OUT_MAX_KHZ = 32'd1600000;
    localparam int          DIV_MAX     = 7;
    localparam int          MUL_MIN     = 8;
    localparam int          MUL_MAX     = 200;
    localparam int          CP_BASE     = 6;
    localparam int          CP_ENTRIES  = 19;
    localparam int          CP_FIRST    = 48;
    localparam int          CP_STEP     = 8;
    localparam int          CP_W        = 5;
    localparam int          DIV_W       = 3;
    localparam int          MUL_W       = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MREQ,
        S_MWAIT,
        S_FREQ,
        S_FWAIT,
        S_FIN
    } search_state_e;

    function automatic logic out_of_range(input logic [31:0] req, input logic [31:0] refk);
        return (req < OUT_MIN_KHZ) || (req > OUT_MAX_KHZ) || (refk == 32'd0);
    endfunction

endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [W:0]       trial;
    logic             fits;

    assign trial = {rem_q, quo_q[W-1]};
    assign fits  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= num;
                den_q  <= den;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= fits ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = quo_q;
endmodule

// File: rtl/pll_cp_lookup.sv
module pll_cp_lookup
    import pll_search_pkg::*;
#(
    parameter int NW = MUL_W
) (
    input  logic [NW-1:0]   mul,
    output logic [CP_W-1:0] code
);
    logic [CP_ENTRIES-1:0] above;

    generate
        for (genvar k = 0; k < CP_ENTRIES; k++) begin : g_thr
            assign above[k] = mul > NW'(CP_FIRST + CP_STEP * k);
        end
    endgenerate

    always_comb begin
        code = CP_W'(CP_BASE);
        for (int k = 0; k < CP_ENTRIES; k++) begin
            code = code + CP_W'(above[k]);
        end
    end
endmodule

// File: rtl/pll_divsearch.sv
module pll_divsearch
    import pll_search_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int CALC_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] ref_khz,
    input  logic [FREQ_W-1:0] req_khz,
    output logic              done,
    output logic              valid,
    output logic [DIV_W-1:0]  idf,
    output logic [MUL_W-1:0]  ndiv,
    output logic [CP_W-1:0]   cp,
    output logic [CALC_W-1:0] rate_hz
);
    search_state_e     st_q;
    logic [FREQ_W-1:0] ref_q;
    logic [FREQ_W-1:0] req_q;
    logic [DIV_W-1:0]  d_q;
    logic [MUL_W-1:0]  m_q;
    logic [CALC_W-1:0] best_err_q;
    logic [DIV_W-1:0]  best_d_q;
    logic [MUL_W-1:0]  best_m_q;
    logic [CALC_W-1:0] best_f_q;

    logic              done_q;
    logic              valid_q;
    logic [DIV_W-1:0]  idf_q;
    logic [MUL_W-1:0]  ndiv_q;
    logic [CP_W-1:0]   cp_q;
    logic [CALC_W-1:0] rate_q;

    logic [CALC_W-1:0] ref_ext;
    logic [CALC_W-1:0] req_ext;
    logic [CALC_W-1:0] div_num;
    logic [CALC_W-1:0] div_den;
    logic              div_start;
    logic              div_busy;
    logic              div_done;
    logic [CALC_W-1:0] div_quot;
    logic [CALC_W-1:0] err;
    logic              keep;
    logic              last_d;
    logic              found;
    logic [CP_W-1:0]   cp_code;

    assign ref_ext   = CALC_W'(ref_q);
    assign req_ext   = CALC_W'(req_q);
    assign div_start = (st_q == S_MREQ) || (st_q == S_FREQ);
    assign div_num   = (st_q == S_MREQ) ? CALC_W'(d_q) * req_ext
                                        : CALC_W'(2) * ref_ext * CALC_W'(m_q);
    assign div_den   = (st_q == S_MREQ) ? CALC_W'(2) * ref_ext : CALC_W'(d_q);

    assign err    = (div_quot >= req_ext) ? div_quot - req_ext : req_ext - div_quot;
    assign keep   = (err == '0) || (err < best_err_q);
    assign last_d = d_q == DIV_W'(DIV_MAX);
    assign found  = best_err_q != '1;

    pll_div_seq #(.W(CALC_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot)
    );

    pll_cp_lookup #(.NW(MUL_W)) u_cp (
        .mul  (best_m_q),
        .code (cp_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            ref_q      <= '0;
            req_q      <= '0;
            d_q        <= '0;
            m_q        <= '0;
            best_err_q <= '1;
            best_d_q   <= '0;
            best_m_q   <= '0;
            best_f_q   <= '0;
            done_q     <= 1'b0;
            valid_q    <= 1'b0;
            idf_q      <= '0;
            ndiv_q     <= '0;
            cp_q       <= '0;
            rate_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (start) begin
                        ref_q      <= ref_khz;
                        req_q      <= req_khz;
                        d_q        <= DIV_W'(1);
                        best_err_q <= '1;
                        best_d_q   <= '0;
                        best_m_q   <= '0;
                        best_f_q   <= '0;
                        st_q       <= out_of_range(req_khz, ref_khz) ? S_FIN : S_MREQ;
                    end
                end
                S_MREQ: st_q <= S_MWAIT;
                S_MWAIT: begin
                    if (div_done) begin
                        if (div_quot < CALC_W'(MUL_MIN)) begin
                            if (last_d) begin
                                st_q <= S_FIN;
                            end else begin
                                d_q  <= d_q + DIV_W'(1);
                                st_q <= S_MREQ;
                            end
                        end else if (div_quot > CALC_W'(MUL_MAX)) begin
                            st_q <= S_FIN;
                        end else begin
                            m_q  <= div_quot[MUL_W-1:0];
                            st_q <= S_FREQ;
                        end
                    end
                end
                S_FREQ: st_q <= S_FWAIT;
                S_FWAIT: begin
                    if (div_done) begin
                        if (keep) begin
                            best_err_q <= err;
                            best_d_q   <= d_q;
                            best_m_q   <= m_q;
                            best_f_q   <= div_quot;
                        end
                        if ((keep && err == '0) || last_d) begin
                            st_q <= S_FIN;
                        end else begin
                            d_q  <= d_q + DIV_W'(1);
                            st_q <= S_MREQ;
                        end
                    end
                end
                S_FIN: begin
                    done_q  <= 1'b1;
                    valid_q <= found;
                    idf_q   <= found ? best_d_q : '0;
                    ndiv_q  <= found ? best_m_q : '0;
                    cp_q    <= found ? cp_code : '0;
                    rate_q  <= found ? best_f_q * CALC_W'(1000) : '0;
                    st_q    <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign done    = done_q;
    assign valid   = valid_q;
    assign idf     = idf_q;
    assign ndiv    = ndiv_q;
    assign cp      = cp_q;
    assign rate_hz = rate_q;

    logic unused_busy;
    assign unused_busy = div_busy;
endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
    parameter int CALC_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              valid,
    input logic [2:0]        idf,
    input logic [7:0]        ndiv,
    input logic [4:0]        cp,
    input logic [CALC_W-1:0] rate_hz
);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(valid) && $stable(idf) && $stable(ndiv) && $stable(cp) && $stable(rate_hz)));

    a_r2_div_range: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> (idf >= 3'd1 && idf <= 3'd7));

    a_r4_mul_range: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> (ndiv >= 8'd8 && ndiv <= 8'd200));

    a_r8_cp_range: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> (cp >= 5'd6 && cp <= 5'd25));

    a_r8_cp_floor: assert property (@(posedge clk) disable iff (rst)
        (done && valid && ndiv <= 8'd48) |-> (cp == 5'd6));

    a_r7_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        (done && !valid) |-> (idf == 3'd0 && ndiv == 8'd0 && cp == 5'd0 && rate_hz == '0));

    a_r9_rate_kilo: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> (rate_hz % CALC_W'(1000) == '0 && rate_hz != '0));
endmodule

bind pll_divsearch pll_search_chk #(.CALC_W(CALC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .valid   (valid),
    .idf     (idf),
    .ndiv    (ndiv),
    .cp      (cp),
    .rate_hz (rate_hz)
);

// File: tb/pll_divsearch_tb.sv
module pll_divsearch_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        v;
        logic [2:0]  d;
        logic [7:0]  m;
        logic [4:0]  c;
        logic [39:0] r;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] ref_khz = '0;
    logic [31:0] req_khz = '0;
    logic        done;
    logic        valid;
    logic [2:0]  idf;
    logic [7:0]  ndiv;
    logic [4:0]  cp;
    logic [39:0] rate_hz;

    int checks = 0;
    int errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  last_exp;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pll_divsearch u_dut (
        .clk(clk), .rst(rst), .start(start), .ref_khz(ref_khz), .req_khz(req_khz),
        .done(done), .valid(valid), .idf(idf), .ndiv(ndiv), .cp(cp), .rate_hz(rate_hz)
    );

    function automatic exp_t model(input longint unsigned rin, input longint unsigned rout);
        exp_t e;
        longint unsigned best, bd, bm, bf, m, f, dev;
        int c;
        e = '0;
        best = '1; bd = 0; bm = 0; bf = 0; c = 6;
        if (rout < 800000 || rout > 1600000 || rin == 0) return e;
        for (int d = 1; d <= 7 && best != 0; d++) begin
            m = (longint'(d) * rout) / (2 * rin);
            if (m < 8) continue;
            if (m > 200) break;
            f = (2 * rin * m) / longint'(d);
            dev = (f > rout) ? f - rout : rout - f;
            if (dev == 0 || dev < best) begin
                best = dev; bd = longint'(d); bm = m; bf = f;
            end
        end
        if (best == '1) return e;
        for (int k = 0; k < 19; k++) if (bm > longint'(48 + 8 * k)) c++;
        e.v = 1'b1; e.d = bd[2:0]; e.m = bm[7:0]; e.c = c[4:0]; e.r = 40'(bf * 1000);
        return e;
    endfunction

    function automatic exp_t actual();
        exp_t a;
        a.v = valid; a.d = idf; a.m = ndiv; a.c = cp; a.r = rate_hz;
        return a;
    endfunction

    task automatic check(input string tag, input exp_t act, input exp_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual v=%0d d=%0d m=%0d cp=%0d rate=%0d expected v=%0d d=%0d m=%0d cp=%0d rate=%0d",
                     tag, act.v, act.d, act.m, act.c, act.r, exp.v, exp.d, exp.m, exp.c, exp.r);
        end
    endtask

    // monitor: pops one expected item per completion pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected done actual 1 expected 0");
            end else begin
                last_exp = exp_q.pop_front();
                check(tag_q.pop_front(), actual(), last_exp);
            end
        end
    end

    task automatic run(input string tag, input logic [31:0] rin, input logic [31:0] rout);
        exp_q.push_back(model(rin, rout));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b1; ref_khz = rin; req_khz = rout;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        exp_t z;
        seed = 32'h1234_5678;
        z = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset state", actual(), z);
        checks++;
        if (done !== 1'b0) begin errors++; $display("FAIL R10 done after reset actual %0d expected 0", done); end

        run("R6 exact on first divider", 32'd25000, 32'd1000000);
        run("R6 exact on third divider", 32'd30000, 32'd1000000);
        run("R1 below range", 32'd25000, 32'd799999);
        run("R1 lower edge", 32'd27000, 32'd800000);
        run("R1 upper edge", 32'd24000, 32'd1600000);
        run("R1 above range", 32'd25000, 32'd1600001);
        run("R1 zero reference", 32'd0, 32'd1000000);
        run("R4 limit on first divider", 32'd3000, 32'd1600000);
        run("R4 limit after kept pair", 32'd10000, 32'd1234567);
        run("R3 all multipliers too small", 32'd700000, 32'd1000000);
        run("R3 skip then accept", 32'd400000, 32'd1000000);
        run("R8 top charge-pump code", 32'd4000, 32'd1560000);
        run("R5 nearest pair", 32'd27000, 32'd1111111);
        run("R9 rate of inexact pair", 32'd19200, 32'd1333333);

        // R10: outputs hold between completions
        repeat (3) @(negedge clk);
        check("R10 hold after done", actual(), last_exp);

        // R10: a strobe during a search is ignored
        exp_q.push_back(model(32'd30000, 32'd1000000));
        tag_q.push_back("R10 busy start ignored");
        @(negedge clk);
        start = 1'b1; ref_khz = 32'd30000; req_khz = 32'd1000000;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1; ref_khz = 32'd25000; req_khz = 32'd799999;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (400) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 pending results actual %0d expected 0", exp_q.size());
        end

        for (int k = 0; k < 10; k++) begin
            logic [31:0] rin, rout;
            seed = seed * 32'd1664525 + 32'd1013904223;
            rin  = 32'd4000 + (seed % 32'd60000);
            seed = seed * 32'd1664525 + 32'd1013904223;
            rout = 32'd800000 + (seed % 32'd800001);
            run("R2 R5 R6 sweep", rin, rout);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule